// File: doc/BRIEF.md
# Lifecycle Transition Sequencer

This block is the control state machine that carries out one request to move a device to a new lifecycle state. From its idle state it either retires the device to a scrapped state, or starts a transition. A transition switches the clock source, then increments and programs a transition counter. It then checks that the requested move is allowed and hashes the unlock token. Next it optionally wipes flash for a return-to-vendor flow, compares the token in two stages, and finally programs the new state. Each external step is modelled as a strobe that the sequencer raises, answered by a shared done or error flag. The real hashing and memory programming happen outside the block.

A failure at any step ends the sequence in a post-transition state, which only reset leaves. Two independent escalation inputs send the machine to a terminal escalate state from anywhere. The state register uses a sparse code, so a corrupted value decodes as invalid and also leads to escalation.

Top module: `lc_seq_fsm`

## Requirements
- R1: While reset is asserted, state_o holds the Reset code 0x1E1, step_o is 0 and tok_err_o is 0. The first clock after reset release moves to Idle.
- R2: In Idle, scrap_i moves to Scrap and wins over start_i. Otherwise start_i moves to ClkMux. With neither, the machine stays in Idle.
- R3: ClkMux holds until done_i and then moves to CntIncr. err_i alone leaves it in ClkMux.
- R4: In CntIncr, CntProg, TransCheck and TokenHash, err_i moves to PostTrans and wins over done_i. done_i alone moves to the next state of that chain (CntProg, TransCheck, TokenHash, FlashRma). With neither, the state holds.
- R5: In FlashRma with rma_i high, the flash strobe is raised and the state holds until done_i, then moves to TokenCheck0. With rma_i low, there is no strobe and the machine moves to TokenCheck0 on the next clock.
- R6: TokenCheck0 and TokenCheck1 each take exactly one clock. A high match_i advances the machine (TokenCheck0 to TokenCheck1, TokenCheck1 to TransProg). A low match_i moves to PostTrans and sets tok_err_o, which stays set until reset. TokenCheck1 never follows itself.
- R7: TransProg holds until done_i or err_i, then moves to PostTrans.
- R8: PostTrans, Scrap and Escalate hold under any mix of start_i, scrap_i, done_i, err_i, match_i and rma_i while no escalation bit is set.
- R9: Any set bit of esc_i moves the machine to Escalate on the next clock, from every state including Reset, PostTrans, Scrap and Invalid.
- R10: State i is coded as {i, ~i, i} in three 4-bit groups. The indices are Reset 1, Idle 2, ClkMux 3, CntIncr 4, CntProg 5, TransCheck 6, TokenHash 7, FlashRma 8, TokenCheck0 9, TokenCheck1 10, TransProg 11, PostTrans 12, Scrap 13, Escalate 14 and Invalid 15. state_o shows the register.
- R11: A state register value that is not one of these codes, and the Invalid code itself, leads to Escalate on the next clock.
- R12: step_o has at most one bit set. Bit 0 is ClkMux, 1 is CntIncr, 2 is CntProg, 3 is TransCheck and 4 is TokenHash. Bit 5 is FlashRma when rma_i is high, bit 6 is either token check, and bit 7 is TransProg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a transition from Idle |
| scrap_i | input | 1 | Request to retire the device from Idle |
| done_i | input | 1 | Current step finished successfully |
| err_i | input | 1 | Current step failed |
| match_i | input | 1 | Token comparison result for the active check stage |
| rma_i | input | 1 | Transition includes a flash wipe |
| esc_i | input | NUM_ESC (2) | Independent escalation requests |
| state_o | output | 12 | Encoded state register |
| step_o | output | 8 | Per-step strobes |
| tok_err_o | output | 1 | Sticky token mismatch flag |

## Verification
The hardest case to reach from the ports is a corrupted state register. No input sequence can produce a non-code value or the Invalid code. The stimulus therefore overwrites the register for an instant between clock edges. It does this with the Invalid code and with single-bit flips of legal codes, then watches the next clock land in Escalate. Every other state is reached by walking the success chain from reset, or by a single failure, before the escalation and hold sweeps are applied.

// File: rtl/lc_seq_pkg.sv
package lc_seq_pkg;
  localparam int GRP_W  = 4;
  localparam int ST_W   = 3 * GRP_W;
  localparam int STEP_N = 8;

  typedef enum logic [ST_W-1:0] {
    ST_RESET   = 12'h1E1,
    ST_IDLE    = 12'h2D2,
    ST_CLKMUX  = 12'h3C3,
    ST_CNTINC  = 12'h4B4,
    ST_CNTPRG  = 12'h5A5,
    ST_TRCHK   = 12'h696,
    ST_THASH   = 12'h787,
    ST_FLWIPE  = 12'h878,
    ST_TCHK0   = 12'h969,
    ST_TCHK1   = 12'hA5A,
    ST_TRPRG   = 12'hB4B,
    ST_POST    = 12'hC3C,
    ST_SCRAP   = 12'hD2D,
    ST_ESC     = 12'hE1E,
    ST_INVALID = 12'hF0F
  } lc_st_e;

  // A legal code repeats its index, with the middle group inverted.
  function automatic logic code_ok(logic [ST_W-1:0] c);
    logic [GRP_W-1:0] lo, mid, hi;
    lo  = c[GRP_W-1:0];
    mid = c[2*GRP_W-1:GRP_W];
    hi  = c[ST_W-1:2*GRP_W];
    return (hi == lo) && (mid == ~lo) && (lo != '0);
  endfunction

  function automatic logic [STEP_N-1:0] step_of(lc_st_e s, logic rma);
    logic [STEP_N-1:0] v;
    v = '0;
    case (s)
      ST_CLKMUX:         v[0] = 1'b1;
      ST_CNTINC:         v[1] = 1'b1;
      ST_CNTPRG:         v[2] = 1'b1;
      ST_TRCHK:          v[3] = 1'b1;
      ST_THASH:          v[4] = 1'b1;
      ST_FLWIPE:         v[5] = rma;
      ST_TCHK0, ST_TCHK1: v[6] = 1'b1;
      ST_TRPRG:          v[7] = 1'b1;
      default:           v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/lc_seq_decode.sv
module lc_seq_decode
  import lc_seq_pkg::*;
(
  input  logic [ST_W-1:0] raw_i,
  output lc_st_e          st_o,
  output logic            illegal_o
);
  assign illegal_o = !code_ok(raw_i);
  assign st_o      = illegal_o ? ST_INVALID : lc_st_e'(raw_i);
endmodule

// File: rtl/lc_seq_next.sv
module lc_seq_next
  import lc_seq_pkg::*;
(
  input  lc_st_e st_i,
  input  logic   esc_i,
  input  logic   start_i,
  input  logic   scrap_i,
  input  logic   done_i,
  input  logic   err_i,
  input  logic   match_i,
  input  logic   rma_i,
  output lc_st_e nxt_o,
  output logic   tok_fail_o
);
  logic in_tchk;
  assign in_tchk    = (st_i == ST_TCHK0) || (st_i == ST_TCHK1);
  assign tok_fail_o = in_tchk && !match_i && !esc_i;

  always_comb begin
    nxt_o = st_i;
    if (esc_i) begin
      nxt_o = ST_ESC;
    end else begin
      case (st_i)
        ST_RESET:  nxt_o = ST_IDLE;
        ST_IDLE:   if (scrap_i) nxt_o = ST_SCRAP;
                   else if (start_i) nxt_o = ST_CLKMUX;
        ST_CLKMUX: if (done_i) nxt_o = ST_CNTINC;
        ST_CNTINC: if (err_i) nxt_o = ST_POST; else if (done_i) nxt_o = ST_CNTPRG;
        ST_CNTPRG: if (err_i) nxt_o = ST_POST; else if (done_i) nxt_o = ST_TRCHK;
        ST_TRCHK:  if (err_i) nxt_o = ST_POST; else if (done_i) nxt_o = ST_THASH;
        ST_THASH:  if (err_i) nxt_o = ST_POST; else if (done_i) nxt_o = ST_FLWIPE;
        ST_FLWIPE: if (!rma_i || done_i) nxt_o = ST_TCHK0;
        ST_TCHK0:  nxt_o = match_i ? ST_TCHK1 : ST_POST;
        ST_TCHK1:  nxt_o = match_i ? ST_TRPRG : ST_POST;
        ST_TRPRG:  if (done_i || err_i) nxt_o = ST_POST;
        ST_POST, ST_SCRAP, ST_ESC: nxt_o = st_i;
        default:   nxt_o = ST_ESC;
      endcase
    end
  end
endmodule

// File: rtl/lc_seq_fsm.sv
module lc_seq_fsm
  import lc_seq_pkg::*;
#(
  parameter int NUM_ESC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               scrap_i,
  input  logic               done_i,
  input  logic               err_i,
  input  logic               match_i,
  input  logic               rma_i,
  input  logic [NUM_ESC-1:0] esc_i,
  output logic [ST_W-1:0]    state_o,
  output logic [STEP_N-1:0]  step_o,
  output logic               tok_err_o
);
  logic [ST_W-1:0] state_q;
  logic            tok_err_q;
  lc_st_e          st_cur, st_nxt;
  logic            illegal, tok_fail, esc_any;

  assign esc_any = |esc_i;

  lc_seq_decode u_dec (
    .raw_i     (state_q),
    .st_o      (st_cur),
    .illegal_o (illegal)
  );

  lc_seq_next u_nxt (
    .st_i       (st_cur),
    .esc_i      (esc_any),
    .start_i    (start_i),
    .scrap_i    (scrap_i),
    .done_i     (done_i),
    .err_i      (err_i),
    .match_i    (match_i),
    .rma_i      (rma_i),
    .nxt_o      (st_nxt),
    .tok_fail_o (tok_fail)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RESET;
      tok_err_q <= 1'b0;
    end else begin
      state_q   <= st_nxt;
      tok_err_q <= tok_err_q | tok_fail;
    end
  end

  assign state_o   = state_q;
  assign step_o    = step_of(st_cur, rma_i);
  assign tok_err_o = tok_err_q;

  // R9
  esc_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_any |=> state_q == ST_ESC);
  // R11
  bad_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal |=> state_q == ST_ESC);
  // R8
  esc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ESC |=> state_q == ST_ESC);
  // R8
  post_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POST && !esc_any) |=> state_q == ST_POST);
  // R6
  tchk1_leave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_TCHK1 |=> state_q != ST_TCHK1);
  // R6
  tok_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_err_q |=> tok_err_q);
  // R12
  step_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(step_o));
  // R1
  reset_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RESET && !esc_any) |=> state_q == ST_IDLE);
endmodule

// File: tb/tb_lc_seq_fsm.sv
module tb_lc_seq_fsm;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, scrap = 0, done = 0, err = 0, match = 0, rma = 0;
  logic [1:0] esc = '0;
  logic [11:0] state;
  logic [7:0] step;
  logic tok_err;
  int nchk = 0, nerr = 0;
  bit finished = 0;

  lc_seq_fsm #(.NUM_ESC(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .scrap_i(scrap),
    .done_i(done), .err_i(err), .match_i(match), .rma_i(rma),
    .esc_i(esc), .state_o(state), .step_o(step), .tok_err_o(tok_err)
  );

  always #5 clk = ~clk;

  function automatic logic [11:0] code(int i);
    logic [3:0] g;
    g = 4'(i);
    return {g, ~g, g};
  endfunction

  function automatic logic [7:0] exp_step(int i, logic r);
    logic [7:0] v;
    v = '0;
    if (i >= 3 && i <= 7) v[i-3] = 1'b1;
    if (i == 8) v[5] = r;
    if (i == 9 || i == 10) v[6] = 1'b1;
    if (i == 11) v[7] = 1'b1;
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setin(logic s, logic sc, logic d, logic e, logic m, logic r, logic [1:0] x);
    start = s; scrap = sc; done = d; err = e; match = m; rma = r; esc = x;
  endtask

  task automatic tick(logic s, logic sc, logic d, logic e, logic m, logic r, logic [1:0] x);
    @(negedge clk);
    setin(s, sc, d, e, m, r, x);
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    setin(0, 0, 0, 0, 0, 0, 2'b00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  // Leaves the machine in state index t (t==1: just after reset release).
  task automatic goto(int t);
    do_reset();
    if (t == 1) return;
    tick(0, 0, 0, 0, 0, 0, 2'b00);
    if (t == 2) return;
    if (t == 13) begin tick(0, 1, 0, 0, 0, 0, 2'b00); return; end
    tick(1, 0, 0, 0, 0, 0, 2'b00);
    if (t == 12) begin
      tick(0, 0, 1, 0, 0, 0, 2'b00);
      tick(0, 0, 0, 1, 0, 0, 2'b00);
      return;
    end
    for (int n = 0; n < 20 && state !== code(t); n++)
      tick(0, 0, 1, 0, 1, 1, 2'b00);
    setin(0, 0, 0, 0, 0, 0, 2'b00);
    #1;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    // R1 reset state and exit
    do_reset();
    chk("R1 state", state, code(1));
    chk("R1 step", step, 0);
    chk("R1 tokerr", tok_err, 0);
    tick(0, 0, 0, 0, 0, 0, 2'b00);
    chk("R1 to idle", state, code(2));

    // R2 idle choices
    tick(0, 0, 0, 0, 0, 0, 2'b00);
    chk("R2 idle hold", state, code(2));
    tick(1, 1, 0, 0, 0, 0, 2'b00);
    chk("R2 scrap wins", state, code(13));
    goto(2);
    tick(1, 0, 0, 0, 0, 0, 2'b00);
    chk("R2 start", state, code(3));

    // R3 clock switch waits for done
    tick(0, 0, 0, 1, 0, 0, 2'b00);
    chk("R3 err ignored", state, code(3));
    tick(0, 0, 1, 0, 0, 0, 2'b00);
    chk("R3 advance", state, code(4));

    // R10/R12 walk: code and strobe in every step state
    for (int t = 3; t <= 11; t++) begin
      goto(t);
      chk("R10 code", state, code(t));
      rma = 1'b1; #1;
      chk("R12 strobe", step, exp_step(t, 1'b1));
      rma = 1'b0; #1;
      chk("R12 strobe norma", step, exp_step(t, 1'b0));
    end

    // R4 error priority, hold, advance in the chain
    for (int t = 4; t <= 7; t++) begin
      goto(t);
      tick(0, 0, 0, 0, 0, 0, 2'b00);
      chk("R4 hold", state, code(t));
      tick(0, 0, 1, 0, 0, 0, 2'b00);
      chk("R4 advance", state, code(t + 1));
      goto(t);
      tick(0, 0, 1, 1, 0, 0, 2'b00);
      chk("R4 err to post", state, code(12));
    end

    // R5 flash wipe with and without rma
    goto(8);
    tick(0, 0, 0, 0, 1, 1, 2'b00);
    chk("R5 rma wait", state, code(8));
    chk("R5 rma strobe", step, 8'h20);
    tick(0, 0, 1, 0, 1, 1, 2'b00);
    chk("R5 rma done", state, code(9));
    goto(8);
    tick(0, 0, 0, 0, 0, 0, 2'b00);
    chk("R5 skip wipe", state, code(9));

    // R6 token checks
    goto(9);
    chk("R6 clean flag", tok_err, 0);
    tick(0, 0, 0, 0, 0, 0, 2'b00);
    chk("R6 tc0 mismatch", state, code(12));
    chk("R6 flag set", tok_err, 1);
    tick(1, 0, 1, 0, 1, 0, 2'b00);
    chk("R6 flag sticky", tok_err, 1);
    goto(10);
    tick(0, 0, 0, 0, 0, 0, 2'b00);
    chk("R6 tc1 mismatch", state, code(12));
    chk("R6 tc1 flag", tok_err, 1);
    goto(10);
    tick(0, 0, 0, 0, 1, 0, 2'b00);
    chk("R6 tc1 match", state, code(11));
    chk("R6 no flag", tok_err, 0);

    // R7 final programming
    goto(11);
    tick(0, 0, 0, 0, 0, 0, 2'b00);
    chk("R7 hold", state, code(11));
    tick(0, 0, 0, 1, 0, 0, 2'b00);
    chk("R7 err to post", state, code(12));
    goto(11);
    tick(0, 0, 1, 0, 0, 0, 2'b00);
    chk("R7 done to post", state, code(12));

    // R8 terminal holds under all non-escalation inputs
    for (int t = 12; t <= 14; t++) begin
      if (t == 14) begin goto(2); tick(0, 0, 0, 0, 0, 0, 2'b01); end
      else goto(t);
      for (int p = 0; p < 64; p++) begin
        logic [5:0] v;
        v = 6'(p);
        tick(v[0], v[1], v[2], v[3], v[4], v[5], 2'b00);
      end
      chk("R8 terminal hold", state, code(t));
    end

    // R9 escalation from every state, each input alone
    for (int t = 1; t <= 13; t++) begin
      for (int e = 0; e < 2; e++) begin
        goto(t);
        if (t == 1) begin
          esc = 2'b01 << e;
          @(posedge clk); #1;
        end else begin
          tick(1, 0, 1, 0, 1, 1, 2'(1 << e));
        end
        chk("R9 escalate", state, code(14));
      end
    end

    // R11 corrupted register, incl. the Invalid code, single flips
    for (int b = -1; b < 12; b++) begin
      goto(2);
      @(negedge clk);
      if (b < 0) force dut.state_q = code(15);
      else       force dut.state_q = code(2) ^ (12'h1 << b);
      #1;
      release dut.state_q;
      @(posedge clk); #1;
      chk("R11 bad code", state, code(14));
    end
    // R9 escalate out of Invalid
    goto(2);
    @(negedge clk);
    force dut.state_q = code(15);
    esc = 2'b10;
    #1;
    release dut.state_q;
    @(posedge clk); #1;
    chk("R9 from invalid", state, code(14));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule